// File: doc/BRIEF.md
# Decimal Matrix Code Protected Memory

This block is a small synchronous memory that keeps 64-bit words safe against clustered upsets. Each word is split into sixteen 4-bit symbols laid out as two rows of eight. Each symbol is paired with the symbol four columns away in the same row. Every pair contributes a 5-bit integer sum, and each column of the two rows contributes one bit-wise XOR. The 64 data bits, 40 sum bits and 32 XOR bits are stored together as one 136-bit codeword.

A single check-bit generator is shared between the two paths. On a write it encodes the incoming data. On a read it recomputes the sums and XORs from the stored data bits. The recomputed values are compared with the stored check bits to form a horizontal syndrome, from integer subtraction, and a vertical syndrome, from XOR. The syndromes locate the damaged symbols, and those symbols are repaired by inverting the flipped bits before the word leaves the block. The repaired word is never written back.

Requests are plain enables sampled on the rising clock edge. The block accepts one request in every cycle and never applies back-pressure. The read response carries a valid strobe but has no ready input, so the consumer must take each response in the cycle it appears. A test-only port XORs a mask into a stored codeword, which lets faults be injected.

Top module: `dmc_protected_mem`

## Requirements
- R1: A read of a word with no injected faults returns the written data with `rd_err` low. Read data and `rd_err` are registered and appear one clock after the read is accepted. `rd_err` is high only in a cycle where `rd_valid` is high.
- R2: `rd_valid` is high for exactly one cycle, the cycle after an accepted read. It is low in every other cycle.
- R3: Reset clears every entry to the all-zero codeword and drives `rd_valid` and `rd_err` low. A read of any address after reset returns zero data with `rd_err` low.
- R4: Any nonzero error pattern confined to one data symbol is corrected and returned with `rd_err` high. Symbol s occupies codeword bits 4s to 4s+3, for s = 0..15.
- R5: Flips confined to the stored check bits, codeword bits 64..135, leave the returned data equal to the written data, with `rd_err` high.
- R6: An 8-bit burst in the data field that starts at any multiple of 4 from 0 to 56 is fully corrected, with `rd_err` high. Such a burst covers two neighbouring symbols, including a burst that crosses from the first row into the second.
- R7: Correction is not written back. Reading a damaged word again returns corrected data and still reports `rd_err` high. A new write to that address removes the damage.
- R8: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and no read response is produced.
- R9: Injection XORs `inj_mask` into the codeword at `inj_addr` only. Other addresses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request; wins over a read in the same cycle |
| rd_en | input | 1 | Read request |
| addr | input | 4 | Word address for both reads and writes |
| wr_data | input | 64 | Data to encode and store |
| rd_data | output | 64 | Corrected read data, registered |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` and `rd_err` as valid |
| rd_err | output | 1 | A nonzero syndrome was seen on the returned word |
| inj_en | input | 1 | Test-only: apply `inj_mask` this cycle |
| inj_addr | input | 4 | Test-only: entry to damage |
| inj_mask | input | 136 | Test-only: bits to flip in the stored codeword |

## Verification
The assertions check the response protocol on every cycle:
- a strobe follows each accepted read and never appears otherwise;
- a collision between a read and a write yields no strobe;
- reset leaves the outputs quiet;
- the error flag never appears without the strobe;
- the returned word never differs from the raw stored data unless the error flag is raised.

Whether a given error pattern is actually repaired can only be shown by the bench's scenarios. These sweep every pattern inside every symbol, every single check-bit flip and every symbol-aligned 8-bit burst against arithmetically generated data. They also cover the no-write-back behaviour and the isolation of injection between addresses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  // Role of the shared check-bit generator in a given cycle.
  typedef enum logic {
    GEN_CHECK  = 1'b0,  // recompute from stored data (read path)
    GEN_ENCODE = 1'b1   // encode incoming data (write path)
  } gen_mode_e;
endpackage

// File: rtl/dmc_checkgen.sv
module dmc_checkgen
  import dmc_pkg::*;
#(
  parameter int SYM_W = 4,
  parameter int COLS  = 8
) (
  input  gen_mode_e                      mode,
  input  logic [2*COLS*SYM_W-1:0]        enc_data,
  input  logic [2*COLS*SYM_W-1:0]        chk_data,
  output logic [COLS*(SYM_W+1)-1:0]      h_bits,
  output logic [COLS*SYM_W-1:0]          v_bits
);
  localparam int ROW_W  = COLS * SYM_W;
  localparam int DATA_W = 2 * ROW_W;
  localparam int HALF   = COLS / 2;
  localparam int SUM_W  = SYM_W + 1;

  logic [DATA_W-1:0] src;

  // One generator, two uses: the write/read control picks the operand.
  assign src = (mode == GEN_ENCODE) ? enc_data : chk_data;

  // Horizontal: integer sum of a symbol and its partner HALF columns away.
  for (genvar g = 0; g < COLS; g++) begin : g_sum
    localparam int ROW = g / HALF;
    localparam int LO  = ROW * ROW_W + (g % HALF) * SYM_W;
    localparam int HI  = LO + HALF * SYM_W;
    assign h_bits[g*SUM_W +: SUM_W] = {1'b0, src[LO +: SYM_W]} + {1'b0, src[HI +: SYM_W]};
  end

  // Vertical: column-wise XOR of the two rows.
  assign v_bits = src[ROW_W-1:0] ^ src[DATA_W-1:ROW_W];
endmodule

// File: rtl/dmc_correct.sv
module dmc_correct #(
  parameter int SYM_W = 4,
  parameter int COLS  = 8
) (
  input  logic [2*COLS*SYM_W-1:0]   raw_data,
  input  logic [COLS*(SYM_W+1)-1:0] st_h,
  input  logic [COLS*SYM_W-1:0]     st_v,
  input  logic [COLS*(SYM_W+1)-1:0] re_h,
  input  logic [COLS*SYM_W-1:0]     re_v,
  output logic [2*COLS*SYM_W-1:0]   fixed_data,
  output logic                      err
);
  localparam int HALF  = COLS / 2;
  localparam int SUM_W = SYM_W + 1;

  logic [COLS-1:0]       h_nz;
  logic [COLS*SYM_W-1:0] s_v;

  // Horizontal syndrome by integer subtraction.
  for (genvar g = 0; g < COLS; g++) begin : g_hsyn
    logic [SUM_W-1:0] delta;
    assign delta   = re_h[g*SUM_W +: SUM_W] - st_h[g*SUM_W +: SUM_W];
    assign h_nz[g] = |delta;
  end

  // Vertical syndrome by XOR.
  assign s_v = re_v ^ st_v;

  // Locator and corrector: a symbol is flipped by its column syndrome
  // only when its own horizontal group also reports a mismatch.
  for (genvar r = 0; r < 2; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int GRP = r * HALF + (c % HALF);
      localparam int POS = (r * COLS + c) * SYM_W;
      logic [SYM_W-1:0] col_s;
      logic             hit;
      assign col_s = s_v[c*SYM_W +: SYM_W];
      assign hit   = h_nz[GRP] & (|col_s);
      assign fixed_data[POS +: SYM_W] = raw_data[POS +: SYM_W] ^ (hit ? col_s : '0);
    end
  end

  assign err = (|h_nz) | (|s_v);
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int CW_W  = 136,
  parameter int DEPTH = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CW_W-1:0]   wcw,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CW_W-1:0]   rcw
);
  logic [CW_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        mem[i] <= '0;
      else if (we && waddr == ADDR_W'(i))
        mem[i] <= wcw;
      else if (inj_en && inj_addr == ADDR_W'(i))
        mem[i] <= mem[i] ^ inj_mask;
    end
  end

  assign rcw = mem[raddr];
endmodule

// File: rtl/dmc_protected_mem.sv
module dmc_protected_mem
  import dmc_pkg::*;
#(
  parameter int SYM_W = 4,
  parameter int COLS  = 8,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = 2 * COLS * SYM_W,
  localparam int H_W    = COLS * (SYM_W + 1),
  localparam int V_W    = COLS * SYM_W,
  localparam int CW_W   = DATA_W + H_W + V_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask
);
  gen_mode_e         mode;
  logic              rd_fire;
  logic [CW_W-1:0]   store_cw;
  logic [CW_W-1:0]   new_cw;
  logic [DATA_W-1:0] stored_d;
  logic [H_W-1:0]    stored_h;
  logic [V_W-1:0]    stored_v;
  logic [H_W-1:0]    gen_h;
  logic [V_W-1:0]    gen_v;
  logic [DATA_W-1:0] fixed_d;
  logic              syn_err;

  assign mode    = wr_en ? GEN_ENCODE : GEN_CHECK;
  assign rd_fire = rd_en & ~wr_en;

  // Codeword layout: data low, horizontal sums next, vertical XORs on top.
  assign stored_d = store_cw[DATA_W-1:0];
  assign stored_h = store_cw[DATA_W +: H_W];
  assign stored_v = store_cw[DATA_W+H_W +: V_W];
  assign new_cw   = {gen_v, gen_h, wr_data};

  dmc_store #(.CW_W(CW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(addr), .wcw(new_cw),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .raddr(addr), .rcw(store_cw)
  );

  dmc_checkgen #(.SYM_W(SYM_W), .COLS(COLS)) u_gen (
    .mode(mode), .enc_data(wr_data), .chk_data(stored_d),
    .h_bits(gen_h), .v_bits(gen_v)
  );

  dmc_correct #(.SYM_W(SYM_W), .COLS(COLS)) u_fix (
    .raw_data(stored_d), .st_h(stored_h), .st_v(stored_v),
    .re_h(gen_h), .re_v(gen_v),
    .fixed_data(fixed_d), .err(syn_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      rd_err   <= rd_fire & syn_err;
      if (rd_fire) rd_data <= fixed_d;
    end
  end
endmodule

// File: rtl/dmc_mem_checker.sv
module dmc_mem_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              rd_err,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] raw_data
);
  p_valid_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_valid);

  p_valid_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !wr_en));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> !rd_valid);

  p_reset_quiet_r3: assert property (@(posedge clk)
    rst |=> (!rd_valid && !rd_err));

  p_err_with_valid_r1: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rd_valid);

  // R4: a returned word that differs from the raw stored bits must be flagged.
  p_change_flagged_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && (rd_data != $past(raw_data))) |-> rd_err);
endmodule

bind dmc_protected_mem dmc_mem_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
  .raw_data(stored_d)
);

// File: tb/tb_dmc_protected_mem.sv
module tb_dmc_protected_mem;
  localparam int DW = 64;
  localparam int CW = 136;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] inj_mask = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_err;

  always #4 clk = ~clk;

  dmc_protected_mem dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    logic [31:0] a, b;
    a = 32'(k) * 32'h9E3779B9 ^ 32'h5A5A0F0F;
    b = 32'(k + 7) * 32'h85EBCA6B;
    return {a, b};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [CW-1:0] m);
    @(negedge clk); inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk); inj_en = 1'b0; inj_mask = '0;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] expd,
                           input logic expe, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid === 1'b1, req, 64'(rd_valid), 64'd1);
    chk(rd_data === expd, req, rd_data, expd);
    chk(rd_err === expe, req, 64'(rd_err), 64'(expe));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R3: outputs quiet during reset
    chk(rd_valid === 1'b0 && rd_err === 1'b0, "R3 reset outputs", {62'd0, rd_valid, rd_err}, 64'd0);
    rst = 1'b0;

    // R3: every entry reads as zero after reset
    for (int a = 0; a < DEPTH; a++) rd_expect(AW'(a), '0, 1'b0, "R3 zero after reset");

    // R1/R2: write all addresses, read back, strobe lasts one cycle
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), pat(a));
    for (int a = 0; a < DEPTH; a++) begin
      rd_expect(AW'(a), pat(a), 1'b0, "R1 clean read");
      @(negedge clk);
      chk(rd_valid === 1'b0, "R2 single-cycle strobe", 64'(rd_valid), 64'd0);
    end

    // R4: every nonzero pattern in every data symbol
    for (int s = 0; s < 16; s++) begin
      for (int e = 1; e < 16; e++) begin
        logic [AW-1:0] a;
        a = AW'(s + e);
        wr(a, pat(s * 16 + e));
        inject(a, CW'(e) << (4 * s));
        rd_expect(a, pat(s * 16 + e), 1'b1, "R4 symbol error corrected");
      end
    end

    // R5: every single check-bit flip
    for (int b = 64; b < CW; b++) begin
      logic [AW-1:0] a;
      a = AW'(b);
      wr(a, pat(b + 300));
      inject(a, CW'(1) << b);
      rd_expect(a, pat(b + 300), 1'b1, "R5 check-bit flip");
    end

    // R6: symbol-aligned 8-bit bursts
    for (int p = 0; p <= 14; p++) begin
      logic [AW-1:0] a;
      a = AW'(p);
      wr(a, ~pat(p + 500));
      inject(a, CW'(8'hFF) << (4 * p));
      rd_expect(a, ~pat(p + 500), 1'b1, "R6 8-bit burst");
    end

    // R7: no write-back; second read still flags, rewrite clears
    wr(AW'(9), pat(777));
    inject(AW'(9), CW'(4'hB) << 36);
    rd_expect(AW'(9), pat(777), 1'b1, "R7 first read");
    rd_expect(AW'(9), pat(777), 1'b1, "R7 second read still flagged");
    wr(AW'(9), pat(778));
    rd_expect(AW'(9), pat(778), 1'b0, "R7 rewrite clears damage");

    // R9: injection touches only its target address
    wr(AW'(3), pat(900));
    wr(AW'(4), pat(901));
    inject(AW'(3), CW'(4'hF) << 8);
    rd_expect(AW'(4), pat(901), 1'b0, "R9 neighbour untouched");
    rd_expect(AW'(3), pat(900), 1'b1, "R9 target damaged");

    // R8: write wins over a simultaneous read
    wr(AW'(5), pat(1000));
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = AW'(5); wr_data = pat(1001);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R8 no response on collision", 64'(rd_valid), 64'd0);
    rd_expect(AW'(5), pat(1001), 1'b0, "R8 write performed");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule